// File: doc/BRIEF.md
# Nucleotide Two-Bit Stream Packer

This block takes a stream of ASCII nucleotide letters, one byte per accepted beat, and packs them into wide words at two bits per letter. The two-bit code is read straight from bits [2:1] of the character, so no lookup table sits in the path. Because that bit pair is identical for an upper-case and a lower-case letter, and for T and U, the same logic covers DNA and RNA in either case.

Characters fill a word from its most significant end downward. A word leaves the block as soon as it holds as many codes as fit (32 in the default 64-bit configuration). A flush request ends the current group early. The block then emits the partial word with its unused low bit pairs cleared, together with the number of valid codes. Both sides use valid/ready handshakes. The output register holds steady under backpressure, and the input stalls while a finished word waits to be taken.

Top module: `nt_pack2`

## Requirements
- R1: The code for a character is its bits [2:1]. This gives A/a=00, C/c=01, T/t=10, U/u=10 and G/g=11.
- R2: The first code of a group occupies word bits [63:62], and each later code occupies the next lower bit pair.
- R3: When the 32nd code of a group is accepted, the block presents the word on the next cycle with count 32, and the next character starts a new group.
- R4: A flush with k pending codes (1 to 31) emits the word with count k, and every bit below the last valid pair is zero.
- R5: When a character and a flush are accepted in the same beat, that character is included in the flushed word.
- R6: A flush with no pending codes and no character produces no output word.
- R7: While out_valid is high and out_ready is low, the word and count stay unchanged and in_ready is low.
- R8: Reset drops out_valid and discards any pending codes, so the first group after reset starts empty.
- R9: A flush that arrives on the beat of the 32nd character produces exactly one word, with count 32, and no extra empty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character is offered |
| in_char | input | 8 | ASCII nucleotide character |
| flush | input | 1 | Close the current group; taken on any beat in which in_ready is high |
| in_ready | output | 1 | Block can take a character or a flush |
| out_valid | output | 1 | Packed word is presented |
| out_word | output | 64 | Packed codes, earliest code in the top pair |
| out_cnt | output | 6 | Number of valid codes in out_word (1 to 32) |
| out_ready | input | 1 | Consumer takes the word |

## Verification
Two pairs of functions can land in one cycle. A flush can coincide with a character, including the character that fills the word (R5, R9). A finished word can also be drained in the same cycle that the next group's first character is accepted. The bench sweeps every group length from 1 to 70. It ends each group either with a flush that rides on the last character or with a separate flush beat, while a periodic out_ready pattern stalls the output. A table-driven model predicts every word and count, and any word beyond the predicted sequence fails, as does any change while the output is stalled.

// File: rtl/nt_pack2.sv
module nt_pack2 #(
  parameter int WORD_W = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [7:0]                 in_char,
  input  logic                       flush,
  output logic                       in_ready,
  output logic                       out_valid,
  output logic [WORD_W-1:0]          out_word,
  output logic [$clog2(WORD_W/2):0]  out_cnt,
  input  logic                       out_ready
);
  localparam int SLOTS = WORD_W / 2;
  localparam int SB    = $clog2(SLOTS);

  logic [WORD_W-1:0] acc, ins;
  logic [SB-1:0]     cnt;
  logic [SB:0]       nxt;
  logic [SB:0]       pos;
  logic              take, emit;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign nxt      = {1'b0, cnt} + {{SB{1'b0}}, take};
  assign emit     = in_ready && (nxt[SB] || (flush && nxt != '0));
  assign pos      = {~cnt, 1'b0};

  always_comb begin
    ins = acc;
    if (take) ins[pos +: 2] = in_char[2:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_cnt   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (emit) begin
        out_valid <= 1'b1;
        out_word  <= ins;
        out_cnt   <= nxt;
        acc       <= '0;
        cnt       <= '0;
      end else if (take) begin
        acc <= ins;
        cnt <= nxt[SB-1:0];
      end
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_cnt));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_cnt != '0 && out_cnt <= (SB+1)'(SLOTS));

  // R4
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cnt < (SB+1)'(SLOTS) |-> out_word[1:0] == 2'b00);

  // R6
  empty_flush_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready && flush && !in_valid && cnt == '0 |=> !out_valid);

  // R2
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    take && !emit |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/nt_pack2_tb.sv
module nt_pack2_tb_top;
  logic clk = 0, rst = 1;
  logic in_valid = 0, flush = 0, out_ready = 0;
  logic [7:0] in_char = 0;
  logic in_ready, out_valid;
  logic [63:0] out_word;
  logic [5:0] out_cnt;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0, bp_on = 0;
  logic [63:0] exp_w[$];
  int exp_n[$];
  logic [63:0] m_acc = 0;
  int m_n = 0;

  always #2 clk = ~clk;

  nt_pack2 dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .flush(flush), .in_ready(in_ready), .out_valid(out_valid), .out_word(out_word),
    .out_cnt(out_cnt), .out_ready(out_ready));

  function automatic logic [1:0] ref_code(input logic [7:0] c);
    case (c)
      "A", "a": return 2'b00;
      "C", "c": return 2'b01;
      "T", "t", "U", "u": return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [7:0] pick(input int i);
    string s = "ACGTUacgtu";
    return s[i % 10];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model update for one accepted beat
  task automatic model(input bit v, input logic [7:0] c, input bit f);
    if (v) begin
      m_acc |= 64'(ref_code(c)) << (62 - 2*m_n);
      m_n++;
    end
    if (m_n == 32 || (f && m_n != 0)) begin
      exp_w.push_back(m_acc);
      exp_n.push_back(m_n);
      m_acc = 0;
      m_n = 0;
    end
  endtask

  task automatic beat(input bit v, input logic [7:0] c, input bit f);
    @(posedge clk); #1;
    in_valid = v; in_char = c; flush = f;
    forever begin
      @(negedge clk); #1;
      if (in_ready) break;
      @(posedge clk); #1;
    end
    model(v, c, f);
    @(posedge clk); #1;
    in_valid = 0; flush = 0;
  endtask

  // output side: ready pattern and checks
  initial begin
    logic [63:0] held_w;
    logic [5:0] held_n;
    bit holding;
    holding = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = bp_on ? ((cyc % 5) != 0 && (cyc % 7) != 3) : 1'b1;
      @(negedge clk); #1;
      if (rst) begin holding = 0; continue; end
      if (holding) begin
        // R7 word held under backpressure
        chk(out_valid && out_word == held_w && out_cnt == held_n, "R7 hold", out_word, held_w);
        holding = 0;
      end
      if (out_valid && !out_ready) begin
        // R7 input stalled while word waits
        chk(!in_ready, "R7 in_ready", {63'd0, in_ready}, 64'd0);
        held_w = out_word; held_n = out_cnt; holding = 1;
      end
      if (out_valid && out_ready) begin
        if (exp_w.size() == 0) begin
          chk(0, "R6 unexpected word", out_word, 64'd0);
        end else begin
          logic [63:0] ew;
          int en;
          ew = exp_w.pop_front();
          en = exp_n.pop_front();
          // R1 R2 code values and order
          chk(out_word == ew, "R1/R2 word", out_word, ew);
          chk(out_cnt == 6'(en), "R3/R4 count", 64'(out_cnt), 64'(en));
          if (en < 32)
            // R4 low pairs zero
            chk((out_word & ((64'd1 << (64 - 2*en)) - 1)) == 0, "R4 zero fill", out_word, ew);
          else
            chk(out_cnt == 6'd32, "R3 full count", 64'(out_cnt), 64'd32);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R8 reset state
    chk(!out_valid && in_ready, "R8 reset", {62'd0, out_valid, in_ready}, 64'd1);

    for (int pass = 0; pass < 2; pass++) begin
      bp_on = (pass == 1);
      for (int len = 1; len <= 70; len++) begin
        for (int i = 0; i < len; i++) begin
          // R5 / R9: flush rides on last character for odd lengths
          beat(1'b1, pick(i*7 + len*3), (i == len-1) && (len % 2 == 1));
        end
        if (len % 2 == 0) beat(1'b0, 8'h00, 1'b1);
      end
    end

    // R9 explicit: 32 chars with flush on the 32nd
    for (int i = 0; i < 32; i++) beat(1'b1, pick(i), i == 31);
    // R6 idle flushes with nothing pending
    for (int i = 0; i < 6; i++) beat(1'b0, 8'h00, 1'b1);
    repeat (10) @(posedge clk);
    @(negedge clk); #1;
    chk(exp_w.size() == 0, "R6/R9 drained", 64'(exp_w.size()), 64'd0);

    // R8 reset discards pending codes
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_char = "G";
      @(posedge clk); #1;
      in_valid = 0;
    end
    rst = 1;
    m_acc = 0; m_n = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    beat(1'b1, "a", 1'b0);
    beat(1'b1, "u", 1'b1);
    repeat (10) @(posedge clk);
    @(negedge clk); #1;
    chk(exp_w.size() == 0, "R8 after reset", 64'(exp_w.size()), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule